// File: doc/BRIEF.md
# Inter-Processor Mailbox with Hardware Mutex

This block lets two processor cores signal each other through a shared register space. Each target core owns one 32-bit mailbox word. A core posts a message into the word of its peer, and the peer receives an interrupt for as long as any bit of that word is set. The receiver clears the bits it has handled, and its interrupt drops once the word is zero. Every word has three write views on the bus. The direct view replaces the whole word. The set view ORs bits in. The clear view removes bits. With the set and clear views, several senders can post or retire individual flags without a read-modify-write race.

The block also holds one hardware mutex flag. A bus read of the mutex register returns whether the flag was free, and that same read takes the flag. A write of 1 gives the flag back. A build parameter widens the block from two mailbox words to six. The extra four words act as software interrupt sources.

Top module: `ipc_mbox_top`

## Requirements
- R1: After reset every mailbox word reads 0, every interrupt output is low and the mutex is free.
- R2: Word addresses are used. Mailbox slot i decodes its direct view at address 4*i. A write there replaces the whole word. A read there returns the word on bus_rd_data in the cycle after the read strobe.
- R3: A mailbox word keeps its value in every cycle in which no write targets one of its views.
- R4: A write to the set view (address 4*i+1) ORs the write data into the word. A data value of zero leaves the word unchanged.
- R5: A write to the clear view (address 4*i+2) clears each bit position written as 1. A data value of zero leaves the word unchanged.
- R6: mbox_irq[i] is high exactly when word i is nonzero. It stays high after a partial clear and falls only once every bit has been cleared.
- R7: A read of the mutex register (address 0xFF) while the mutex is free returns 1 in bit 0, and the mutex becomes held.
- R8: A read of the mutex register while the mutex is held returns 0 and leaves it held.
- R9: A write to the mutex register with bit 0 set releases the mutex. A write with bit 0 clear has no effect.
- R10: With SW_IRQ_EN=0 there are two slots, and addresses 8 and above behave as unused. With SW_IRQ_EN=1 there are six slots, at addresses 0 through 23, each with its own interrupt.
- R11: A read of an unused address, of offset 3 of a slot, or of a set or clear view returns 0. A write to an unused address changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | DATA_W | Read data, valid the cycle after the read strobe |
| mbox_irq | output | NUM_SLOTS | Interrupt request per mailbox slot |

## Verification
The embedded assertions check on every cycle that a word stays the same when none of its views is written, and that a set write keeps every earlier bit. They also check that a clear write leaves no targeted bit set, and that an interrupt edge is always caused by a write of the matching kind. On the mutex they check the taken, held and released transitions, and they check that unused addresses read back as zero. Other behaviours depend on exact data values and on the address map, and only the bench scenarios can show them. These are the full replacement by a direct write, the arithmetic results of set and clear patterns across every slot of both build variants, and the sequence of mutex read values.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    typedef enum logic [1:0] {
        VIEW_DIRECT = 2'd0,
        VIEW_SET    = 2'd1,
        VIEW_CLEAR  = 2'd2,
        VIEW_RSVD   = 2'd3
    } mbox_view_e;

    function automatic int slot_count(bit sw_irq_en);
        return sw_irq_en ? 6 : 2;
    endfunction

endpackage

// File: rtl/ipc_mbox_slot.sv
module ipc_mbox_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_dir) begin
            st_d.word = wdata;
        end else if (wr_set) begin
            st_d.word = st_q.word | wdata;
        end else if (wr_clr) begin
            st_d.word = st_q.word & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign irq  = |st_q.word;

    // R3: no write, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dir || wr_set || wr_clr) |=> $stable(word));

    // R4: set view never drops a bit
    a_r4_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((word & $past(word)) == $past(word)));

    // R5: clear view leaves no targeted bit set
    a_r5_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((word & $past(wdata)) == '0));

    // R6: interrupt rises only after a direct or set write
    a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_dir || wr_set));

    // R6: interrupt falls only after a direct or clear write
    a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_dir || wr_clr));

endmodule

// File: rtl/ipc_mbox_mutex.sv
module ipc_mbox_mutex (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic release_req,
    output logic free
);

    typedef struct packed {
        logic free;
    } mtx_state_t;

    mtx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (release_req) begin
            st_d.free = 1'b1;
        end else if (take) begin
            st_d.free = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.free <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign free = st_q.free;

    // R7: a read of a free mutex takes it
    a_r7_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take && free && !release_req) |=> !free);

    // R8: a read of a held mutex keeps it held
    a_r8_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!free && !release_req) |=> !free);

    // R9: writing 1 releases
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> free);

endmodule

// File: rtl/ipc_mbox_top.sv
module ipc_mbox_top
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter bit SW_IRQ_EN = 1'b0,
    parameter int NUM_SLOTS = slot_count(SW_IRQ_EN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [DATA_W-1:0]    bus_wr_data,
    input  logic                 bus_rd_en,
    output logic [DATA_W-1:0]    bus_rd_data,
    output logic [NUM_SLOTS-1:0] mbox_irq
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] MUTEX_ADDR = {ADDR_W{1'b1}};
    localparam logic [IDX_W-1:0]  SLOT_LIM   = IDX_W'(NUM_SLOTS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [IDX_W-1:0]  slot_idx;
    mbox_view_e        view;
    logic              slot_hit;
    logic              mutex_hit;
    logic              mtx_free;
    logic [DATA_W-1:0] words [NUM_SLOTS];

    assign slot_idx  = bus_addr[ADDR_W-1:2];
    assign view      = mbox_view_e'(bus_addr[1:0]);
    assign mutex_hit = (bus_addr == MUTEX_ADDR);
    assign slot_hit  = !mutex_hit && (slot_idx < SLOT_LIM);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic sel;
        assign sel = bus_wr_en && slot_hit && (slot_idx == IDX_W'(g));

        ipc_mbox_slot #(.DATA_W(DATA_W)) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dir (sel && (view == VIEW_DIRECT)),
            .wr_set (sel && (view == VIEW_SET)),
            .wr_clr (sel && (view == VIEW_CLEAR)),
            .wdata  (bus_wr_data),
            .word   (words[g]),
            .irq    (mbox_irq[g])
        );
    end

    ipc_mbox_mutex i_mutex (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (bus_rd_en && mutex_hit),
        .release_req (bus_wr_en && mutex_hit && bus_wr_data[0]),
        .free        (mtx_free)
    );

    always_comb begin
        st_d = '0;
        if (bus_rd_en) begin
            if (mutex_hit) begin
                st_d.rdata = {{(DATA_W-1){1'b0}}, mtx_free};
            end else if (slot_hit && (view == VIEW_DIRECT)) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (slot_idx == IDX_W'(i)) begin
                        st_d.rdata = words[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rd_data = st_q.rdata;

    // R11: unused addresses and write-only views read as zero
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && !mutex_hit && !(slot_hit && (view == VIEW_DIRECT)))
        |=> (bus_rd_data == '0));

    // R8: a read of a held mutex returns zero
    a_r8_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && mutex_hit && !mtx_free) |=> (bus_rd_data == '0));

endmodule

// File: tb/test_ipc_mbox_top.sv
module test_ipc_mbox_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic        re = 1'b0;
    logic [31:0] rd_n, rd_w;
    logic [1:0]  irq_n;
    logic [5:0]  irq_w;

    int total = 0;
    int bad   = 0;

    logic [31:0] mn [6];
    logic [31:0] mw [6];

    always #5 clk = ~clk;

    ipc_mbox_top i_ipc_mbox_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(we),
        .bus_wr_data(wd), .bus_rd_en(re), .bus_rd_data(rd_n), .mbox_irq(irq_n)
    );

    ipc_mbox_top #(.SW_IRQ_EN(1'b1)) i_ipc_mbox_top_wide (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(we),
        .bus_wr_data(wd), .bus_rd_en(re), .bus_rd_data(rd_w), .mbox_irq(irq_w)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        // model update: slot s at 4s, views at offsets 0,1,2
        if (a != 8'hFF && a[7:2] < 6) begin
            for (int s = 0; s < 6; s++) begin
                if (a[7:2] == 6'(s)) begin
                    case (a[1:0])
                        2'd0: begin mw[s] = d; if (s < 2) mn[s] = d; end
                        2'd1: begin mw[s] = mw[s] | d; if (s < 2) mn[s] = mn[s] | d; end
                        2'd2: begin mw[s] = mw[s] & ~d; if (s < 2) mn[s] = mn[s] & ~d; end
                        default: ;
                    endcase
                end
            end
        end
    endtask

    task automatic do_rd(input logic [7:0] a);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic check_slot(input string req, input int s);
        do_rd(8'(4 * s));
        check(req, rd_n, (s < 2) ? mn[s] : 32'h0);
        check(req, rd_w, mw[s]);
    endtask

    task automatic check_irq(input string req);
        logic [5:0] ew;
        ew = '0;
        for (int s = 0; s < 6; s++) ew[s] = |mw[s];
        check(req, {30'b0, irq_n}, {30'b0, |mn[1], |mn[0]});
        check(req, {26'b0, irq_w}, {26'b0, ew});
    endtask

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 6; s++) begin mn[s] = '0; mw[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_irq("R1");
        for (int s = 0; s < 6; s++) check_slot("R1", s);

        // R2 R4 R5 R10 sweep across every slot
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < 4; k++) begin
                do_wr(8'(4 * s), 32'h9E3779B9 * 32'(s * 4 + k + 1));
                check_slot((s < 2) ? "R2" : "R10", s);
                do_wr(8'(4 * s + 1), 32'h0000_0101 << (k * 4 + s));
                check_slot("R4", s);
                do_wr(8'(4 * s + 1), 32'h0);
                check_slot("R4", s);
                do_wr(8'(4 * s + 2), 32'hF0F0_F0F0 >> k);
                check_slot("R5", s);
                do_wr(8'(4 * s + 2), 32'h0);
                check_slot("R5", s);
                check_irq("R6");
                do_rd(8'(4 * s + 1));
                check("R11", rd_n, 32'h0);
                check("R11", rd_w, 32'h0);
                check_slot("R3", (s + 5) % 6);
            end
        end

        // R6: partial clear keeps the interrupt
        for (int s = 0; s < 6; s++) do_wr(8'(4 * s + 2), 32'hFFFF_FFFF);
        check_irq("R6");
        do_wr(8'd5, 32'h3);
        do_wr(8'd6, 32'h1);
        check_irq("R6");
        check("R6", {31'b0, irq_n[1]}, 32'h1);
        do_wr(8'd6, 32'h2);
        check("R6", {31'b0, irq_n[1]}, 32'h0);
        check_irq("R6");

        // R11: unused addresses
        do_wr(8'd3, 32'hFFFF_FFFF);
        do_wr(8'd200, 32'hFFFF_FFFF);
        check_slot("R11", 0);
        check_irq("R11");
        do_rd(8'd3);   check("R11", rd_n, 32'h0); check("R11", rd_w, 32'h0);
        do_rd(8'd24);  check("R11", rd_w, 32'h0);
        do_rd(8'd250); check("R11", rd_n, 32'h0); check("R11", rd_w, 32'h0);
        do_rd(8'd10);  check("R11", rd_w, 32'h0);
        // R10: narrow build ignores slot 2
        do_wr(8'd8, 32'hA5A5_0001);
        check_slot("R10", 2);
        check_irq("R10");

        // R7 R8 R9: mutex sequence
        do_rd(8'hFF); check("R7", rd_n, 32'h1); check("R7", rd_w, 32'h1);
        do_rd(8'hFF); check("R8", rd_n, 32'h0); check("R8", rd_w, 32'h0);
        do_rd(8'hFF); check("R8", rd_n, 32'h0);
        do_wr(8'hFF, 32'hFFFF_FFFE);
        do_rd(8'hFF); check("R9", rd_n, 32'h0); check("R9", rd_w, 32'h0);
        do_wr(8'hFF, 32'h1);
        do_rd(8'hFF); check("R9", rd_n, 32'h1); check("R9", rd_w, 32'h1);
        do_rd(8'hFF); check("R8", rd_n, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule